// File: doc/BRIEF.md
# SPI Memory Slave Command Engine

This block is the serial front end of a byte-wide memory of up to 32K locations. A host drives chip select, serial clock and serial data-in. The block drives serial data-out together with an output-enable that an I/O cell uses to tri-state the pin. The serial pins are brought into the system clock domain through two-stage synchronisers, and serial clock edges are found by comparing successive synchronised samples. Every action then runs on the system clock.

Each chip-select-low period carries one command. The first byte is an opcode. The block decodes it and either:
- raises a strobe toward an external protection unit,
- shifts the status byte out or a new status byte in, or
- collects a 16-bit address and streams data bytes to or from a synchronous memory port until chip select rises.

Written bytes commit only when all eight bits have arrived and the protection unit permits the current address. The address wraps from the top of the array back to zero. A HOLD input pauses a transfer without losing its place. A sleep command locks out every opcode except wake.

Top module: `spi_mem_cmd`

## Requirements
- R1: Opcode 06h gives one `wen_set` pulse and opcode 04h gives one `wen_clr` pulse. An opcode outside the set 06h, 04h, 05h, 01h, 03h, 02h, B9h, ABh causes no strobe and no output.
- R2: Bits are taken on rising serial-clock edges, MSB first, and `so` changes only after falling edges. A transfer behaves the same whether the clock idles low (mode 0) or high (mode 3) when chip select falls.
- R3: Each chip-select-low period runs one command. Bytes that follow a command's own bytes are ignored until chip select goes high and low again.
- R4: Opcode 03h takes two address bytes, MSB first, with bit 15 ignored. It then shifts out memory data MSB first, one byte per eight clocks with no gap. The address rises by one per byte and wraps from 7FFFh to 0000h.
- R5: Opcode 02h takes two address bytes, then writes each complete data byte with one `mem_we` pulse at `mem_addr`, only when `wr_ok` is high. The address then advances by one, wrapping at the top, whether or not the byte was written.
- R6: A data byte cut short by chip select rising before its eighth bit is never written.
- R7: Opcode 05h shifts out `stat_rdata`, repeating once per byte while clocked. Opcode 01h gives one `stat_we` pulse carrying the following byte on `stat_wdata`. The status layout is: bit 1 is the write-enable latch and bits 3:2 select the protected region (01 upper quarter, 10 upper half, 11 all).
- R8: `so_oe` is high only while read data or status is being shifted out. It is low during opcode, address and write bytes, and whenever chip select is high.
- R9: While `hold_n` is low, serial clock edges are ignored and `so_oe` is low. After `hold_n` returns high, the transfer continues from the same bit.
- R10: After opcode B9h, every opcode other than ABh is ignored, with no strobe and no output. ABh returns the block to normal.
- R11: After reset, `so_oe` is low, no strobe is active and the block is awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_addr` |
| wr_ok | input | 1 | Protection unit permits a write at `mem_addr` |
| stat_rdata | input | 8 | Status byte from the protection unit |
| wen_set | output | 1 | Set the write-enable latch |
| wen_clr | output | 1 | Clear the write-enable latch |
| stat_we | output | 1 | Status write strobe |
| stat_wdata | output | 8 | Status write data |

## Verification
The assertions assume the serial pins are slow compared with `clk`. Each serial clock phase must last at least four system cycles, so that the two synchroniser stages and the one-cycle memory read settle between edges. They also assume that `hold_n` and `cs_n` do not change within one synchroniser delay of a serial clock edge. The stimulus holds every serial clock phase for six system cycles and changes pins only on falling system clock edges. It changes `hold_n` only while the serial clock is idle high after a completed byte. It leaves several serial phases between a chip-select edge and the first clock edge.

// File: rtl/spi_mem_cmd.sv
module spi_mem_cmd #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  input  logic [7:0]        mem_rdata,
  input  logic              wr_ok,
  input  logic [7:0]        stat_rdata,
  output logic              wen_set,
  output logic              wen_clr,
  output logic              stat_we,
  output logic [7:0]        stat_wdata
);

  localparam logic [7:0] OP_WEN   = 8'h06;
  localparam logic [7:0] OP_WDIS  = 8'h04;
  localparam logic [7:0] OP_SRD   = 8'h05;
  localparam logic [7:0] OP_SWR   = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_WAKE  = 8'hAB;

  typedef enum logic [2:0] {S_CMD, S_ADDR, S_WDAT, S_RDAT, S_SOUT, S_SIN, S_SKIP} st_t;

  logic [3:0] sync1, sync2;
  logic       sck_d;
  st_t        st;
  logic [2:0] bitcnt;
  logic [7:0] rx_sh, tx_sh, addr_hi;
  logic       hi_done, is_rd, out_on, wr_adv, sleep_r;
  logic [ADDR_W-1:0] addr;

  wire cs_s   = sync2[3];
  wire sck_s  = sync2[2];
  wire si_s   = sync2[1];
  wire hold_s = sync2[0];

  wire active    = !cs_s && hold_s;
  wire rise      = active && sck_s && !sck_d;
  wire fall      = active && !sck_s && sck_d;
  wire [7:0] rx_byte = {rx_sh[6:0], si_s};
  wire byte_done = rise && (bitcnt == 3'd7);
  wire out_st    = (st == S_RDAT) || (st == S_SOUT);
  wire [15:0] full_addr = {addr_hi, rx_byte};

  assign mem_addr = addr;
  assign so       = so_oe & tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 4'b1001;
      sync2 <= 4'b1001;
      sck_d <= 1'b0;
      st <= S_CMD;
      bitcnt <= '0;
      rx_sh <= '0;
      tx_sh <= '0;
      addr_hi <= '0;
      hi_done <= 1'b0;
      is_rd <= 1'b0;
      out_on <= 1'b0;
      wr_adv <= 1'b0;
      sleep_r <= 1'b0;
      addr <= '0;
      so_oe <= 1'b0;
      mem_we <= 1'b0;
      mem_wdata <= '0;
      wen_set <= 1'b0;
      wen_clr <= 1'b0;
      stat_we <= 1'b0;
      stat_wdata <= '0;
    end else begin
      sync1 <= {cs_n, sck, si, hold_n};
      sync2 <= sync1;
      sck_d <= sck_s;
      mem_we <= 1'b0;
      wen_set <= 1'b0;
      wen_clr <= 1'b0;
      stat_we <= 1'b0;
      wr_adv <= 1'b0;
      so_oe <= active && out_on;
      if (wr_adv) addr <= addr + 1'b1;

      if (cs_s) begin
        st <= S_CMD;
        bitcnt <= '0;
        hi_done <= 1'b0;
        out_on <= 1'b0;
      end else begin
        if (rise) begin
          rx_sh <= rx_byte;
          bitcnt <= bitcnt + 3'd1;
        end
        if (byte_done) begin
          case (st)
            S_CMD: begin
              st <= S_SKIP;
              if (sleep_r) begin
                if (rx_byte == OP_WAKE) sleep_r <= 1'b0;
              end else begin
                case (rx_byte)
                  OP_WEN:   wen_set <= 1'b1;
                  OP_WDIS:  wen_clr <= 1'b1;
                  OP_SRD:   st <= S_SOUT;
                  OP_SWR:   st <= S_SIN;
                  OP_READ:  begin st <= S_ADDR; is_rd <= 1'b1; end
                  OP_WRITE: begin st <= S_ADDR; is_rd <= 1'b0; end
                  OP_SLEEP: sleep_r <= 1'b1;
                  default:  st <= S_SKIP;
                endcase
              end
            end
            S_ADDR: begin
              if (!hi_done) begin
                addr_hi <= rx_byte;
                hi_done <= 1'b1;
              end else begin
                addr <= full_addr[ADDR_W-1:0];
                st <= is_rd ? S_RDAT : S_WDAT;
              end
            end
            S_WDAT: begin
              mem_we <= wr_ok;
              mem_wdata <= rx_byte;
              wr_adv <= 1'b1;
            end
            S_RDAT: addr <= addr + 1'b1;
            S_SIN: begin
              stat_we <= 1'b1;
              stat_wdata <= rx_byte;
              st <= S_SKIP;
            end
            default: ;
          endcase
        end
        if (fall && out_st && bitcnt == 3'd0) begin
          tx_sh <= (st == S_RDAT) ? mem_rdata : stat_rdata;
          out_on <= 1'b1;
        end else if (fall && out_on) begin
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end

endmodule

module spi_mem_cmd_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              hold_s,
  input logic              so_oe,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              wr_ok,
  input logic              wen_set,
  input logic              wen_clr,
  input logic              stat_we,
  input logic              sleep_r
);

  a_r8_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !so_oe);

  a_r9_oe_off_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_s |=> !so_oe);

  a_r5_write_permitted: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(wr_ok));

  a_r5_addr_steps_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

  a_r6_no_write_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !mem_we);

  a_r10_quiet_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_r |-> !(mem_we || wen_set || wen_clr || stat_we || so_oe));

  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, wen_set, wen_clr, stat_we}));

endmodule

bind spi_mem_cmd spi_mem_cmd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .hold_s(hold_s), .so_oe(so_oe),
  .mem_we(mem_we), .mem_addr(mem_addr), .wr_ok(wr_ok), .wen_set(wen_set),
  .wen_clr(wen_clr), .stat_we(stat_we), .sleep_r(sleep_r)
);

// File: tb/spi_mem_cmd_test.sv
module spi_mem_cmd_test;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sck = 0, si = 0, hold_n = 1;
  logic so, so_oe, mem_we, wr_ok, wen_set, wen_clr, stat_we;
  logic [14:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 0, stat_rdata, stat_wdata;

  always #4 clk = ~clk;

  spi_mem_cmd uut (.*);

  logic [7:0] ram [int];
  logic p_wel = 0;
  logic [7:0] p_sr = 0;

  function automatic bit prot(input int a, input logic [7:0] sr);
    case (sr[3:2])
      2'd1: return a >= 'h6000;
      2'd2: return a >= 'h4000;
      2'd3: return 1;
      default: return 0;
    endcase
  endfunction

  assign stat_rdata = {p_sr[7:2], p_wel, p_sr[0]};
  assign wr_ok = p_wel && !prot(int'(mem_addr), p_sr);

  always @(posedge clk) begin
    if (mem_we) ram[int'(mem_addr)] = mem_wdata;
    mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
    if (wen_set) p_wel <= 1;
    if (wen_clr) p_wel <= 0;
    if (stat_we && p_wel) p_sr <= stat_wdata;
  end

  int total = 0, fails = 0;
  bit done = 0;
  bit m3 = 0;
  logic exp_wel = 0, asleep_m = 0;
  logic [7:0] exp_sr = 0;
  logic [7:0] ref_mem [int];
  logic [7:0] wq[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  int cs_hi = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (cs_hi > 4) check(!so_oe && !mem_we, "R8 idle while deselected", {so_oe, mem_we}, 0);
      cs_hi = cs_n ? cs_hi + 1 : 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] rd_ref(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  task automatic cs_begin();
    sck = m3; tick(2*HALF);
    cs_n = 0; tick(2*HALF);
  endtask

  task automatic cs_end();
    if (!m3) begin sck = 0; tick(HALF); end
    else tick(HALF);
    cs_n = 1; tick(3*HALF);
  endtask

  task automatic xfer_bit(input logic b, output logic r, output logic oe);
    sck = 0; si = b; tick(HALF);
    r = so; oe = so_oe;
    sck = 1; tick(HALF);
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] exp_rx, input logic exp_oe, input string tag);
    logic [7:0] rx;
    logic oe_ok = 1;
    for (int i = 7; i >= 0; i--) begin
      logic r, oe;
      xfer_bit(tx[i], r, oe);
      rx[i] = r;
      if (oe !== exp_oe) oe_ok = 0;
    end
    check(oe_ok && (!exp_oe || rx === exp_rx), tag, {oe_ok, rx}, {1'b1, exp_oe ? exp_rx : rx});
  endtask

  task automatic cmd1(input logic [7:0] op, input string tag);
    cs_begin();
    xfer(op, 0, 0, tag);
    cs_end();
    if (!asleep_m) begin
      if (op == 8'h06) exp_wel = 1;
      if (op == 8'h04) exp_wel = 0;
      if (op == 8'hB9) asleep_m = 1;
    end else if (op == 8'hAB) asleep_m = 0;
  endtask

  task automatic write_seq(input logic [15:0] a, input int partial, input string tag);
    cs_begin();
    xfer(8'h02, 0, 0, tag);
    xfer(a[15:8], 0, 0, tag);
    xfer(a[7:0], 0, 0, tag);
    foreach (wq[i]) begin
      int ad = (int'(a) + i) & 'h7FFF;
      xfer(wq[i], 0, 0, tag);
      if (exp_wel && !prot(ad, exp_sr)) ref_mem[ad] = wq[i];
    end
    for (int k = 0; k < partial; k++) begin
      logic r, oe;
      xfer_bit(1'b1, r, oe);
    end
    cs_end();
  endtask

  task automatic read_seq(input logic [15:0] a, input int n, input string tag);
    cs_begin();
    xfer(8'h03, 0, 0, tag);
    xfer(a[15:8], 0, 0, tag);
    xfer(a[7:0], 0, 0, tag);
    for (int i = 0; i < n; i++)
      xfer(8'h00, rd_ref((int'(a) + i) & 'h7FFF), 1, tag);
    cs_end();
  endtask

  initial begin
    tick(5); rst_n = 1; tick(4);
    // R11
    check(!so_oe && !mem_we && !wen_set && !stat_we, "R11 reset state", {so_oe, mem_we, wen_set, stat_we}, 0);

    m3 = 0; cmd1(8'h06, "R1 enable opcode");
    check(p_wel == exp_wel, "R1 enable latch set", p_wel, exp_wel);
    m3 = 1; cmd1(8'h04, "R1 disable opcode");
    check(p_wel == exp_wel, "R1 enable latch cleared", p_wel, exp_wel);
    m3 = 0; cmd1(8'h06, "R1 enable again");

    // R1 R3 unknown opcode then a trailing byte that looks like a disable
    cs_begin(); xfer(8'h5A, 0, 0, "R1 unknown opcode"); xfer(8'h04, 0, 0, "R3 trailing byte"); cs_end();
    check(p_wel == 1, "R1 unknown opcode no effect", p_wel, 1);
    // R3 enable followed by an extra disable-coded byte
    cs_begin(); xfer(8'h06, 0, 0, "R3 enable"); xfer(8'h04, 0, 0, "R3 extra byte"); cs_end();
    check(p_wel == 1, "R3 extra byte ignored", p_wel, 1);

    // R5 R4 R2 write mode 0, read back in mode 3 with bit 15 set
    m3 = 0; wq = {8'hA1, 8'hB2, 8'hC3}; write_seq(16'h1234, 0, "R5 write stream");
    m3 = 1; read_seq(16'h9234, 3, "R4 R2 read stream mode 3");
    m3 = 0; read_seq(16'h1235, 2, "R4 R2 read stream mode 0");

    // R4 R5 wrap at the top
    wq = {8'h11, 8'h22, 8'h33}; write_seq(16'h7FFE, 0, "R5 write wrap");
    read_seq(16'h7FFF, 2, "R4 read wrap");
    check(ram.exists(0) && ram[0] == 8'h33, "R5 wrapped byte at 0000h", ram.exists(0) ? ram[0] : 8'hXX, 8'h33);

    // R6 partial byte
    m3 = 1; wq = {8'h55}; write_seq(16'h0100, 5, "R6 partial write");
    check(!ram.exists('h101), "R6 partial byte not committed", ram.exists('h101), 0);
    read_seq(16'h0100, 2, "R6 read after partial");

    // R7 status write and repeated status read
    m3 = 0;
    cs_begin(); xfer(8'h01, 0, 0, "R7 status write"); xfer(8'h0C, 0, 0, "R7 status byte"); cs_end();
    if (exp_wel) exp_sr = 8'h0C;
    cs_begin(); xfer(8'h05, 0, 0, "R7 status opcode");
    xfer(8'h00, {exp_sr[7:2], exp_wel, exp_sr[0]}, 1, "R7 status out");
    xfer(8'h00, {exp_sr[7:2], exp_wel, exp_sr[0]}, 1, "R7 status repeats");
    cs_end();
    // R5 protected write
    wq = {8'h77}; write_seq(16'h0200, 0, "R5 protected write");
    check(!ram.exists('h200), "R5 protected byte blocked", ram.exists('h200), 0);
    read_seq(16'h0200, 1, "R5 read protected");
    cs_begin(); xfer(8'h01, 0, 0, "R7 status clear"); xfer(8'h00, 0, 0, "R7 status clear byte"); cs_end();
    if (exp_wel) exp_sr = 8'h00;
    check(p_sr == exp_sr, "R7 status register value", p_sr, exp_sr);

    // R9 hold in a read
    wq = {8'h3C, 8'hC3}; write_seq(16'h0300, 0, "R9 setup");
    cs_begin();
    xfer(8'h03, 0, 0, "R9 read opcode"); xfer(8'h03, 0, 0, "R9 addr hi"); xfer(8'h00, 0, 0, "R9 addr lo");
    xfer(8'h00, 8'h3C, 1, "R9 byte before hold");
    hold_n = 0; tick(2*HALF);
    check(!so_oe, "R9 output off in hold", so_oe, 0);
    for (int k = 0; k < 3; k++) begin sck = 0; tick(HALF); sck = 1; tick(HALF); end
    check(!so_oe, "R9 output off while clocked in hold", so_oe, 0);
    hold_n = 1; tick(2*HALF);
    xfer(8'h00, 8'hC3, 1, "R9 byte after hold");
    cs_end();

    // R10 sleep
    m3 = 1; cmd1(8'hB9, "R10 sleep");
    cmd1(8'h04, "R10 disable while asleep");
    check(p_wel == 1, "R10 disable ignored while asleep", p_wel, 1);
    cs_begin();
    xfer(8'h03, 0, 0, "R10 read opcode asleep"); xfer(8'h03, 0, 0, "R10 addr"); xfer(8'h00, 0, 0, "R10 addr");
    xfer(8'h00, 0, 0, "R10 no output asleep");
    cs_end();
    cmd1(8'hAB, "R10 wake");
    cmd1(8'h04, "R10 disable after wake");
    check(p_wel == 0, "R10 disable works after wake", p_wel, 0);

    // R5 write with latch clear is blocked
    m3 = 0; wq = {8'h99}; write_seq(16'h0400, 0, "R5 write without enable");
    check(!ram.exists('h400), "R5 unlatched write blocked", ram.exists('h400), 0);

    foreach (ref_mem[a])
      check(ram.exists(a) && ram[a] == ref_mem[a], "R5 memory contents", ram.exists(a) ? ram[a] : 8'hXX, ref_mem[a]);

    finish_run();
  end
endmodule